// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the sequencing controller of a multicycle 32-bit load/store processor. Each instruction is carried through a series of clock steps. In every step the controller drives the write enables, the multiplexer selects and the ALU operation class for an external datapath. Its inputs are the opcode and function fields of the instruction register and the overflow flag of the ALU. The instruction set includes register-register arithmetic, word load and store, immediate add, equal and not-equal branches, an absolute jump and a return from an exception handler.

Two faults take the processor into a handler: an opcode the controller does not know, and arithmetic overflow in a register-register operation. Each fault has an entry step that records a cause code and saves the faulting instruction's address in the exception PC. Fetch has already advanced the PC by one word, so the entry step makes the ALU subtract four from the PC to form that address. The same step loads the handler vector into the PC. The return instruction copies the saved address back into the PC. The state number is also brought out, so that the step order can be observed.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in state 0 on the next rising edge, including in the middle of an instruction.
- R2: State 0 (fetch) drives mem_rd, ir_wr, pc_wr, addr_sel=0, alu_a_sel=0, alu_b_sel=01 (constant 4), alu_op=00 (add) and pc_sel=000 (ALU result). It always moves to state 1.
- R3: State 1 (decode) drives alu_a_sel=0, alu_b_sel=11 (shifted offset) and alu_op=00. It dispatches on the opcode: 0x00 goes to 6; 0x23, 0x2B and 0x08 go to 2; 0x04 goes to 8; 0x05 goes to 11; 0x02 goes to 9; 0x10 with function 0x10 goes to 14.
- R4: State 2 drives alu_a_sel=1, alu_b_sel=10 (sign-extended immediate) and alu_op=00. A load (0x23) then passes through state 3 (mem_rd, addr_sel=1) and state 4 (reg_wr, wb_data_sel=1, wb_dst_sel=0), and returns to 0.
- R5: A store (0x2B) goes 2 → 5 and then returns to 0. State 5 drives mem_wr with addr_sel=1.
- R6: An immediate add (0x08) goes 2 → 10 and then returns to 0. State 10 drives reg_wr with wb_dst_sel=0 and wb_data_sel=0.
- R7: A register-register op goes to state 6 (alu_a_sel=1, alu_b_sel=00, alu_op=10). Without overflow it continues to state 7 (reg_wr, wb_dst_sel=1, wb_data_sel=0) and returns to 0.
- R8: If overflow is present in state 6, the next state is 12 and state 7 is skipped, so no register write takes place. State 12 drives alu_a_sel=0, alu_b_sel=01, alu_op=01 (subtract), cause_wr, epc_wr, pc_wr, pc_sel=011 (handler vector) and cause_code=1. It then returns to 0.
- R9: Any other opcode, including 0x10 with a function other than 0x10, goes to state 13. State 13 drives the same signals as state 12, but with cause_code=0, and then returns to 0.
- R10: The equal branch completes in state 8 and the not-equal branch in state 11. Both drive alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_wr_cond and pc_sel=001 (registered ALU result). br_ne is 0 in state 8 and 1 in state 11.
- R11: The jump completes in state 9, which drives pc_wr with pc_sel=010 (jump target).
- R12: The return from an exception completes in state 14, which drives pc_wr with pc_sel=100 (exception PC).
- R13: In every state other than 6, alu_ovf has no effect on the state sequence. Every control not listed for a state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| alu_ovf | input | 1 | ALU signed-overflow flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write gated by the branch condition |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| cause_wr | output | 1 | Cause register load |
| epc_wr | output | 1 | Exception PC load |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 00 register B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function-field decode |
| pc_sel | output | 3 | PC source code |
| wb_dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| wb_data_sel | output | 1 | Write-back data: 0 ALU result, 1 memory data |
| br_ne | output | 1 | Branch polarity: 0 equal, 1 not equal |
| cause_code | output | 1 | Cause value: 0 undefined opcode, 1 overflow |
| state_o | output | 4 | Current state number |

## Verification
The overflow flag and the instruction sequence meet in one cycle: in state 6, the flag decides between the write-back step and the overflow entry step. The bench runs the same register-register opcode with the flag low and with the flag high. It checks, at the falling edge after execute, that the first run shows state 7 with reg_wr set and the second shows state 12 with reg_wr clear and cause_code=1. The flag is also held high through immediate-add and load sequences, and those sequences must keep their normal step order.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   localparam int ST_W = 4;

   typedef enum logic [ST_W-1:0] {
      S_FETCH  = 4'd0,
      S_DECODE = 4'd1,
      S_ADDR   = 4'd2,
      S_LDMEM  = 4'd3,
      S_LDWB   = 4'd4,
      S_STMEM  = 4'd5,
      S_REXEC  = 4'd6,
      S_RWB    = 4'd7,
      S_BEQ    = 4'd8,
      S_JMP    = 4'd9,
      S_IWB    = 4'd10,
      S_BNE    = 4'd11,
      S_XOVF   = 4'd12,
      S_XUND   = 4'd13,
      S_XRET   = 4'd14
   } st_e;

   typedef enum logic [3:0] {
      C_RTYPE, C_LOAD, C_STORE, C_ADDI, C_BEQ, C_BNE, C_JMP, C_RFE, C_UNDEF
   } opclass_e;

   localparam logic [2:0] PCS_ALU    = 3'b000;
   localparam logic [2:0] PCS_ALUOUT = 3'b001;
   localparam logic [2:0] PCS_JUMP   = 3'b010;
   localparam logic [2:0] PCS_VEC    = 3'b011;
   localparam logic [2:0] PCS_EPC    = 3'b100;

   localparam logic [1:0] BSEL_REG  = 2'b00;
   localparam logic [1:0] BSEL_FOUR = 2'b01;
   localparam logic [1:0] BSEL_IMM  = 2'b10;
   localparam logic [1:0] BSEL_OFS  = 2'b11;

   localparam logic [1:0] AOP_ADD  = 2'b00;
   localparam logic [1:0] AOP_SUB  = 2'b01;
   localparam logic [1:0] AOP_FUNC = 2'b10;

   typedef struct packed {
      logic       pc_wr;
      logic       pc_wr_cond;
      logic       mem_rd;
      logic       mem_wr;
      logic       ir_wr;
      logic       reg_wr;
      logic       cause_wr;
      logic       epc_wr;
      logic       addr_sel;
      logic       alu_a_sel;
      logic [1:0] alu_b_sel;
      logic [1:0] alu_op;
      logic [2:0] pc_sel;
      logic       wb_dst_sel;
      logic       wb_data_sel;
      logic       br_ne;
      logic       cause_code;
   } ctrl_t;

endpackage

// File: rtl/mcc_opdec.sv
module mcc_opdec
   import mcc_pkg::*;
#(
   parameter int          OP_W      = 6,
   parameter int          FN_W      = 6,
   parameter logic [5:0]  OP_RTYPE  = 6'h00,
   parameter logic [5:0]  OP_JMP    = 6'h02,
   parameter logic [5:0]  OP_BEQ    = 6'h04,
   parameter logic [5:0]  OP_BNE    = 6'h05,
   parameter logic [5:0]  OP_ADDI   = 6'h08,
   parameter logic [5:0]  OP_LOAD   = 6'h23,
   parameter logic [5:0]  OP_STORE  = 6'h2B,
   parameter logic [5:0]  OP_RFE    = 6'h10,
   parameter logic [5:0]  FN_RFE    = 6'h10
) (
   input  logic [OP_W-1:0] opcode,
   input  logic [FN_W-1:0] funct,
   output opclass_e        opclass
);

   localparam logic [OP_W-1:0] K_RTYPE = OP_W'(OP_RTYPE);
   localparam logic [OP_W-1:0] K_JMP   = OP_W'(OP_JMP);
   localparam logic [OP_W-1:0] K_BEQ   = OP_W'(OP_BEQ);
   localparam logic [OP_W-1:0] K_BNE   = OP_W'(OP_BNE);
   localparam logic [OP_W-1:0] K_ADDI  = OP_W'(OP_ADDI);
   localparam logic [OP_W-1:0] K_LOAD  = OP_W'(OP_LOAD);
   localparam logic [OP_W-1:0] K_STORE = OP_W'(OP_STORE);
   localparam logic [OP_W-1:0] K_RFE   = OP_W'(OP_RFE);
   localparam logic [FN_W-1:0] K_FNRFE = FN_W'(FN_RFE);

   logic rfe_fn_hit;
   assign rfe_fn_hit = (funct == K_FNRFE);

   always_comb begin
      opclass = C_UNDEF;
      if (opcode == K_RTYPE)      opclass = C_RTYPE;
      else if (opcode == K_LOAD)  opclass = C_LOAD;
      else if (opcode == K_STORE) opclass = C_STORE;
      else if (opcode == K_ADDI)  opclass = C_ADDI;
      else if (opcode == K_BEQ)   opclass = C_BEQ;
      else if (opcode == K_BNE)   opclass = C_BNE;
      else if (opcode == K_JMP)   opclass = C_JMP;
      else if (opcode == K_RFE && rfe_fn_hit) opclass = C_RFE;
   end

endmodule

// File: rtl/mcc_next.sv
module mcc_next
   import mcc_pkg::*;
(
   input  st_e      cur,
   input  opclass_e opclass,
   input  logic     alu_ovf,
   output st_e      nxt
);

   always_comb begin
      nxt = S_FETCH;
      unique case (cur)
         S_FETCH:  nxt = S_DECODE;
         S_DECODE: begin
            unique case (opclass)
               C_RTYPE: nxt = S_REXEC;
               C_LOAD,
               C_STORE,
               C_ADDI:  nxt = S_ADDR;
               C_BEQ:   nxt = S_BEQ;
               C_BNE:   nxt = S_BNE;
               C_JMP:   nxt = S_JMP;
               C_RFE:   nxt = S_XRET;
               default: nxt = S_XUND;
            endcase
         end
         S_ADDR: begin
            if (opclass == C_LOAD)       nxt = S_LDMEM;
            else if (opclass == C_STORE) nxt = S_STMEM;
            else                         nxt = S_IWB;
         end
         S_LDMEM:  nxt = S_LDWB;
         S_REXEC:  nxt = alu_ovf ? S_XOVF : S_RWB;
         default:  nxt = S_FETCH;
      endcase
   end

endmodule

// File: rtl/mcc_outdec.sv
module mcc_outdec
   import mcc_pkg::*;
(
   input  st_e   cur,
   output ctrl_t ctl
);

   always_comb begin
      ctl = '0;
      unique case (cur)
         S_FETCH: begin
            ctl.mem_rd    = 1'b1;
            ctl.ir_wr     = 1'b1;
            ctl.pc_wr     = 1'b1;
            ctl.alu_b_sel = BSEL_FOUR;
            ctl.alu_op    = AOP_ADD;
            ctl.pc_sel    = PCS_ALU;
         end
         S_DECODE: begin
            ctl.alu_b_sel = BSEL_OFS;
            ctl.alu_op    = AOP_ADD;
         end
         S_ADDR: begin
            ctl.alu_a_sel = 1'b1;
            ctl.alu_b_sel = BSEL_IMM;
            ctl.alu_op    = AOP_ADD;
         end
         S_LDMEM: begin
            ctl.mem_rd   = 1'b1;
            ctl.addr_sel = 1'b1;
         end
         S_LDWB: begin
            ctl.reg_wr      = 1'b1;
            ctl.wb_data_sel = 1'b1;
         end
         S_STMEM: begin
            ctl.mem_wr   = 1'b1;
            ctl.addr_sel = 1'b1;
         end
         S_REXEC: begin
            ctl.alu_a_sel = 1'b1;
            ctl.alu_b_sel = BSEL_REG;
            ctl.alu_op    = AOP_FUNC;
         end
         S_RWB: begin
            ctl.reg_wr     = 1'b1;
            ctl.wb_dst_sel = 1'b1;
         end
         S_BEQ, S_BNE: begin
            ctl.alu_a_sel  = 1'b1;
            ctl.alu_b_sel  = BSEL_REG;
            ctl.alu_op     = AOP_SUB;
            ctl.pc_wr_cond = 1'b1;
            ctl.pc_sel     = PCS_ALUOUT;
            ctl.br_ne      = (cur == S_BNE);
         end
         S_JMP: begin
            ctl.pc_wr  = 1'b1;
            ctl.pc_sel = PCS_JUMP;
         end
         S_IWB: begin
            ctl.reg_wr = 1'b1;
         end
         S_XOVF, S_XUND: begin
            ctl.alu_b_sel  = BSEL_FOUR;
            ctl.alu_op     = AOP_SUB;
            ctl.cause_wr   = 1'b1;
            ctl.epc_wr     = 1'b1;
            ctl.pc_wr      = 1'b1;
            ctl.pc_sel     = PCS_VEC;
            ctl.cause_code = (cur == S_XOVF);
         end
         S_XRET: begin
            ctl.pc_wr  = 1'b1;
            ctl.pc_sel = PCS_EPC;
         end
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
   import mcc_pkg::*;
#(
   parameter int OP_W = 6,
   parameter int FN_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] opcode,
   input  logic [FN_W-1:0] funct,
   input  logic            alu_ovf,
   output logic            pc_wr,
   output logic            pc_wr_cond,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic            ir_wr,
   output logic            reg_wr,
   output logic            cause_wr,
   output logic            epc_wr,
   output logic            addr_sel,
   output logic            alu_a_sel,
   output logic [1:0]      alu_b_sel,
   output logic [1:0]      alu_op,
   output logic [2:0]      pc_sel,
   output logic            wb_dst_sel,
   output logic            wb_data_sel,
   output logic            br_ne,
   output logic            cause_code,
   output logic [ST_W-1:0] state_o
);

   generate
      if (OP_W != 6) begin : g_bad_op_w
         $error("mc_ctrl_fsm: OP_W must be 6");
      end
      if (FN_W != 6) begin : g_bad_fn_w
         $error("mc_ctrl_fsm: FN_W must be 6");
      end
   endgenerate

   st_e      cur_q, nxt;
   opclass_e opclass;
   ctrl_t    ctl;

   mcc_opdec #(.OP_W(OP_W), .FN_W(FN_W)) u_opdec (
      .opcode  (opcode),
      .funct   (funct),
      .opclass (opclass)
   );

   mcc_next u_next (
      .cur     (cur_q),
      .opclass (opclass),
      .alu_ovf (alu_ovf),
      .nxt     (nxt)
   );

   mcc_outdec u_outdec (
      .cur (cur_q),
      .ctl (ctl)
   );

   always_ff @(posedge clk) begin
      if (rst) cur_q <= S_FETCH;
      else     cur_q <= nxt;
   end

   assign pc_wr       = ctl.pc_wr;
   assign pc_wr_cond  = ctl.pc_wr_cond;
   assign mem_rd      = ctl.mem_rd;
   assign mem_wr      = ctl.mem_wr;
   assign ir_wr       = ctl.ir_wr;
   assign reg_wr      = ctl.reg_wr;
   assign cause_wr    = ctl.cause_wr;
   assign epc_wr      = ctl.epc_wr;
   assign addr_sel    = ctl.addr_sel;
   assign alu_a_sel   = ctl.alu_a_sel;
   assign alu_b_sel   = ctl.alu_b_sel;
   assign alu_op      = ctl.alu_op;
   assign pc_sel      = ctl.pc_sel;
   assign wb_dst_sel  = ctl.wb_dst_sel;
   assign wb_data_sel = ctl.wb_data_sel;
   assign br_ne       = ctl.br_ne;
   assign cause_code  = ctl.cause_code;
   assign state_o     = cur_q;

endmodule

// File: rtl/mcc_chk.sv
module mcc_chk #(
   parameter int OP_W = 6
) (
   input logic            clk,
   input logic            rst,
   input logic [OP_W-1:0] opcode,
   input logic            alu_ovf,
   input logic            mem_rd,
   input logic            mem_wr,
   input logic            reg_wr,
   input logic [3:0]      state_o
);

   assert_rst_fetch_R1: assert property (@(posedge clk)
      rst |=> state_o == 4'd0);

   assert_fetch_decode_R2: assert property (@(posedge clk) disable iff (rst)
      state_o == 4'd0 |=> state_o == 4'd1);

   assert_load_wb_R4: assert property (@(posedge clk) disable iff (rst)
      state_o == 4'd3 |=> state_o == 4'd4);

   assert_addi_wb_R6: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd2 && opcode == 6'h08) |=> state_o == 4'd10);

   assert_no_ovf_wb_R7: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd6 && !alu_ovf) |=> (state_o == 4'd7 && reg_wr));

   assert_ovf_entry_R8: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd6 && alu_ovf) |=> (state_o == 4'd12 && !reg_wr));

   assert_exc_return_R9: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd12 || state_o == 4'd13) |=> state_o == 4'd0);

   assert_mem_excl_R13: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

endmodule

bind mc_ctrl_fsm mcc_chk #(.OP_W(OP_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .opcode  (opcode),
   .alu_ovf (alu_ovf),
   .mem_rd  (mem_rd),
   .mem_wr  (mem_wr),
   .reg_wr  (reg_wr),
   .state_o (state_o)
);

// File: tb/sim_mc_ctrl_fsm.sv
module sim_mc_ctrl_fsm;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst, alu_ovf;
   logic [5:0] opcode, funct;
   logic       pc_wr, pc_wr_cond, mem_rd, mem_wr, ir_wr, reg_wr, cause_wr, epc_wr;
   logic       addr_sel, alu_a_sel, wb_dst_sel, wb_data_sel, br_ne, cause_code;
   logic [1:0] alu_b_sel, alu_op;
   logic [2:0] pc_sel;
   logic [3:0] state_o;

   int nchk = 0;
   int nfail = 0;

   mc_ctrl_fsm u0 (
      .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .alu_ovf(alu_ovf),
      .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .ir_wr(ir_wr), .reg_wr(reg_wr), .cause_wr(cause_wr), .epc_wr(epc_wr),
      .addr_sel(addr_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
      .alu_op(alu_op), .pc_sel(pc_sel), .wb_dst_sel(wb_dst_sel),
      .wb_data_sel(wb_data_sel), .br_ne(br_ne), .cause_code(cause_code),
      .state_o(state_o)
   );

   // Control bus order: pc_wr pc_wr_cond mem_rd mem_wr ir_wr reg_wr cause_wr epc_wr
   // addr_sel alu_a_sel alu_b_sel[2] alu_op[2] pc_sel[3] wb_dst_sel wb_data_sel br_ne cause_code
   wire [20:0] ctrl_bus = {pc_wr, pc_wr_cond, mem_rd, mem_wr, ir_wr, reg_wr, cause_wr,
                           epc_wr, addr_sel, alu_a_sel, alu_b_sel, alu_op, pc_sel,
                           wb_dst_sel, wb_data_sel, br_ne, cause_code};

   function automatic logic [20:0] exp_ctrl(input logic [3:0] s);
      logic pw = 0, pwc = 0, mr = 0, mw = 0, iw = 0, rw = 0, cw = 0, ew = 0;
      logic ad = 0, aa = 0, dst = 0, dat = 0, ne = 0, cc = 0;
      logic [1:0] bb = 2'b00, op = 2'b00;
      logic [2:0] ps = 3'b000;
      case (s)
         4'd0:  begin mr = 1; iw = 1; pw = 1; bb = 2'b01; end             // R2
         4'd1:  bb = 2'b11;                                              // R3
         4'd2:  begin aa = 1; bb = 2'b10; end                            // R4
         4'd3:  begin mr = 1; ad = 1; end                                // R4
         4'd4:  begin rw = 1; dat = 1; end                               // R4
         4'd5:  begin mw = 1; ad = 1; end                                // R5
         4'd6:  begin aa = 1; op = 2'b10; end                            // R7
         4'd7:  begin rw = 1; dst = 1; end                               // R7
         4'd8:  begin aa = 1; op = 2'b01; pwc = 1; ps = 3'b001; end      // R10
         4'd11: begin aa = 1; op = 2'b01; pwc = 1; ps = 3'b001; ne = 1; end
         4'd9:  begin pw = 1; ps = 3'b010; end                           // R11
         4'd10: rw = 1;                                                  // R6
         4'd12: begin bb = 2'b01; op = 2'b01; cw = 1; ew = 1; pw = 1; ps = 3'b011; cc = 1; end // R8
         4'd13: begin bb = 2'b01; op = 2'b01; cw = 1; ew = 1; pw = 1; ps = 3'b011; end         // R9
         4'd14: begin pw = 1; ps = 3'b100; end                           // R12
         default: ;
      endcase
      return {pw, pwc, mr, mw, iw, rw, cw, ew, ad, aa, bb, op, ps, dst, dat, ne, cc};
   endfunction

   function automatic string req_of(input logic [3:0] s);
      case (s)
         4'd0: return "R2";
         4'd1: return "R3";
         4'd2, 4'd3, 4'd4: return "R4";
         4'd5: return "R5";
         4'd10: return "R6";
         4'd6, 4'd7: return "R7";
         4'd12: return "R8";
         4'd13: return "R9";
         4'd8, 4'd11: return "R10";
         4'd9: return "R11";
         4'd14: return "R12";
         default: return "R13";
      endcase
   endfunction

   task automatic check_at(input logic [3:0] s, input string tag);
      nchk++;
      if (state_o !== s) begin
         nfail++;
         $display("FAIL %s state actual %0d expected %0d", tag, state_o, s);
      end
      nchk++;
      if (ctrl_bus !== exp_ctrl(s)) begin
         nfail++;
         $display("FAIL %s controls in state %0d actual %h expected %h", tag, s, ctrl_bus, exp_ctrl(s));
      end
   endtask

   task automatic run_path(input logic [5:0] op, input logic [5:0] fn, input logic ov,
                           input int len, input logic [19:0] path, input string tag);
      opcode = op; funct = fn; alu_ovf = ov;
      for (int k = 0; k < len; k++) begin
         logic [3:0] s;
         s = path[19-4*k -: 4];
         check_at(s, (tag == "") ? req_of(s) : tag);
         @(posedge clk); @(negedge clk);
      end
      check_at(4'd0, (tag == "") ? "R2" : tag);
   endtask

   // {opcode, funct, ovf, len, five state nibbles (first state at the top)}
   localparam int NV = 11;
   localparam logic [35:0] VEC [NV] = '{
      {6'h23, 6'h00, 1'b0, 3'd5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4},
      {6'h2B, 6'h00, 1'b0, 3'd4, 4'd0, 4'd1, 4'd2, 4'd5, 4'd0},
      {6'h08, 6'h00, 1'b0, 3'd4, 4'd0, 4'd1, 4'd2, 4'd10, 4'd0},
      {6'h00, 6'h20, 1'b0, 3'd4, 4'd0, 4'd1, 4'd6, 4'd7, 4'd0},
      {6'h00, 6'h20, 1'b1, 3'd4, 4'd0, 4'd1, 4'd6, 4'd12, 4'd0},
      {6'h04, 6'h00, 1'b0, 3'd3, 4'd0, 4'd1, 4'd8, 4'd0, 4'd0},
      {6'h05, 6'h00, 1'b0, 3'd3, 4'd0, 4'd1, 4'd11, 4'd0, 4'd0},
      {6'h02, 6'h00, 1'b0, 3'd3, 4'd0, 4'd1, 4'd9, 4'd0, 4'd0},
      {6'h10, 6'h10, 1'b0, 3'd3, 4'd0, 4'd1, 4'd14, 4'd0, 4'd0},
      {6'h3F, 6'h00, 1'b0, 3'd3, 4'd0, 4'd1, 4'd13, 4'd0, 4'd0},
      {6'h10, 6'h00, 1'b0, 3'd3, 4'd0, 4'd1, 4'd13, 4'd0, 4'd0}
   };

   bit done = 0;

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL R2 watchdog actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      rst = 1; opcode = 6'h00; funct = 6'h00; alu_ovf = 0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check_at(4'd0, "R1");                  // reset state
      rst = 0;

      for (int v = 0; v < NV; v++) begin
         logic [35:0] e;
         e = VEC[v];
         run_path(e[35:30], e[29:24], e[23], int'(e[22:20]), e[19:0], "");
      end

      // R13: overflow held high outside execute must not divert the sequence
      run_path(6'h08, 6'h00, 1'b1, 4, {4'd0, 4'd1, 4'd2, 4'd10, 4'd0}, "R13");
      run_path(6'h23, 6'h00, 1'b1, 5, {4'd0, 4'd1, 4'd2, 4'd3, 4'd4}, "R13");
      run_path(6'h05, 6'h00, 1'b1, 3, {4'd0, 4'd1, 4'd11, 4'd0, 4'd0}, "R13");

      // R1: reset in the middle of a load, while in state 3
      opcode = 6'h23; alu_ovf = 0;
      repeat (3) begin @(posedge clk); @(negedge clk); end
      check_at(4'd3, "R4");
      rst = 1;
      @(posedge clk); @(negedge clk);
      check_at(4'd0, "R1");
      rst = 0;
      @(posedge clk); @(negedge clk);
      check_at(4'd1, "R1");
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      check_at(4'd0, "R4");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule